// File: doc/BRIEF.md
# Power-On Self-Asserting Reset Synchronizer

This block gives downstream logic an active-high synchronous reset that is already asserted when the device leaves configuration, with no external reset source needed. Its flops start at one, and the chain has no reset of its own. Zeros shift in only on edges of the user clock, so the release can begin no earlier than the first clock edges after the global startup enable has reached the flops. Downstream registers therefore all see the same cycle of release, even though the startup enable reaches them with skew.

An optional active-high external reset feeds the bottom of the chain. When a design has no such source, the `USE_EXT` parameter ties the chain input to zero inside the block, and the block acts as a pure power-on reset that releases by itself. `DEPTH` sets the number of stages. Choose a value that gives more release cycles than the worst-case skew of the startup enable. The minimum is 2, and a smaller value stops elaboration.

The block has no valid/ready interface, because no data passes through it. All pins are plain control signals.

Top module: `por_reset_sync`

## Requirements
- R1: `rst_o` is 1 at power-up, before any clock edge, and stays 1 through the first `DEPTH`-1 rising edges whatever `ext_rst_i` does.
- R2: If the chain input is 0 from power-up onward, `rst_o` falls right after the `DEPTH`-th rising edge and then stays 0 while the input stays 0.
- R3: After every rising edge n with n ≥ `DEPTH`, `rst_o` equals the chain input sampled at edge n-`DEPTH`+1. The input enters the least significant stage, and the output is the most significant stage.
- R4: An external reset pulse that is sampled high on k consecutive edges makes `rst_o` high for exactly k cycles. The high window starts right after the `DEPTH`-1-th edge following the pulse's first edge, so the output goes high within `DEPTH` cycles.
- R5: Once `ext_rst_i` has been sampled high on `DEPTH` or more consecutive edges, `rst_o` stays high with no low cycle for as long as the input stays high.
- R6: With `USE_EXT` = 0, `ext_rst_i` has no effect, and `rst_o` falls right after the `DEPTH`-th edge and stays 0 from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | User clock; every stage changes only on its rising edge |
| ext_rst_i | input | 1 | Optional external reset, active high; tie low when unused |
| rst_o | output | 1 | Synchronous reset for downstream logic, active high |

## Verification
The checker tests four rules on every clock cycle:
- the output stays high until `DEPTH` edges have passed since power-up;
- `DEPTH` consecutive low samples of the chain input force the output low;
- `DEPTH` consecutive high samples force it high;
- with the external input disabled, the output is low once `DEPTH` edges have passed.

Those rules are bounds rather than exact timing. Only the bench scenarios show the exact delay of one fewer than `DEPTH` edges, the exact width of short pulses (single and isolated pulses on a deep chain), and the power-up level before the first edge. The bench runs three instances with different depths and input modes against a delay-line model, so it also confirms that the depth parameter and the input mode really change the timing.

// File: rtl/por_pkg.sv
package por_pkg;

  // Smallest chain that still re-times the release to the user clock.
  localparam int POR_MIN_DEPTH = 2;

  // Width of a counter able to hold 0..limit.
  function automatic int por_cnt_w(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/por_stage.sv
module por_stage #(
  parameter bit PWR_UP_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic d_i,
  output logic q_o
);

  // Power-up value comes from the configuration image; no reset pin on purpose.
  logic q_r = PWR_UP_VAL;

  always_ff @(posedge clk_i) begin
    q_r <= d_i;
  end

  assign q_o = q_r;

endmodule

// File: rtl/por_src_select.sv
module por_src_select #(
  parameter bit USE_EXT = 1'b1
) (
  input  logic ext_i,
  output logic chain_d_o
);

  localparam logic EXT_EN = USE_EXT;

  // Without an external source the chain is fed a constant zero.
  assign chain_d_o = ext_i & EXT_EN;

endmodule

// File: rtl/por_shift_chain.sv
module por_shift_chain #(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic d_i,
  output logic q_o
);

  // tap[0] is the chain input; tap[DEPTH] is the most significant stage.
  logic [DEPTH:0] tap;

  assign tap[0] = d_i;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    por_stage #(
      .PWR_UP_VAL(1'b1)
    ) u_stage (
      .clk_i (clk_i),
      .d_i   (tap[s]),
      .q_o   (tap[s+1])
    );
  end

  assign q_o = tap[DEPTH];

endmodule

// File: rtl/por_reset_sync.sv
module por_reset_sync
  import por_pkg::*;
#(
  parameter int DEPTH   = 2,
  parameter bit USE_EXT = 1'b1
) (
  input  logic clk_i,
  input  logic ext_rst_i,
  output logic rst_o
);

  if (DEPTH < POR_MIN_DEPTH) begin : g_depth_check
    $error("por_reset_sync: DEPTH must be at least %0d", POR_MIN_DEPTH);
  end

  logic chain_d;

  por_src_select #(
    .USE_EXT(USE_EXT)
  ) u_src (
    .ext_i     (ext_rst_i),
    .chain_d_o (chain_d)
  );

  por_shift_chain #(
    .DEPTH(DEPTH)
  ) u_chain (
    .clk_i (clk_i),
    .d_i   (chain_d),
    .q_o   (rst_o)
  );

endmodule

// File: rtl/por_reset_sync_chk.sv
module por_reset_sync_chk
  import por_pkg::*;
#(
  parameter int DEPTH   = 2,
  parameter bit USE_EXT = 1'b1
) (
  input logic clk_i,
  input logic ext_rst_i,
  input logic rst_o
);

  localparam int CW = por_cnt_w(DEPTH);
  localparam logic [CW-1:0] LIM = CW'(DEPTH);

  logic          started = 1'b0;
  logic [CW-1:0] edges   = '0;
  logic [CW-1:0] zrun    = '0;
  logic [CW-1:0] orun    = '0;
  logic          src;

  assign src = USE_EXT ? ext_rst_i : 1'b0;

  always_ff @(posedge clk_i) begin
    started <= 1'b1;
    if (edges != LIM) edges <= edges + 1'b1;
    if (src) begin
      zrun <= '0;
      if (orun != LIM) orun <= orun + 1'b1;
    end else begin
      orun <= '0;
      if (zrun != LIM) zrun <= zrun + 1'b1;
    end
  end

  AST_HELD_AFTER_POWERUP: assert property (@(posedge clk_i) disable iff (!started)
    (edges < LIM) |-> rst_o);  // R1

  AST_RELEASE_AFTER_ZEROS: assert property (@(posedge clk_i) disable iff (!started)
    (zrun == LIM) |-> !rst_o);  // R2

  AST_NO_GLITCH_WHILE_HELD: assert property (@(posedge clk_i) disable iff (!started)
    (orun == LIM) |-> rst_o);  // R5

  AST_EXT_IGNORED: assert property (@(posedge clk_i) disable iff (!started)
    (!USE_EXT && edges == LIM) |-> !rst_o);  // R6

endmodule

bind por_reset_sync por_reset_sync_chk #(
  .DEPTH(DEPTH),
  .USE_EXT(USE_EXT)
) u_chk (
  .clk_i     (clk_i),
  .ext_rst_i (ext_rst_i),
  .rst_o     (rst_o)
);

// File: tb/tb_por_reset_sync.sv
module tb_por_reset_sync;

  localparam int D_A = 2;  // default instance
  localparam int D_B = 6;  // deep instance, external input used
  localparam int D_C = 5;  // external input disabled

  typedef struct {
    int    inst;
    logic  exp;
    string tag;
  } sb_item_t;

  logic clk = 1'b0;
  logic ext = 1'b0;
  logic rst_a, rst_b, rst_c;

  int total = 0;
  int bad   = 0;
  int edge_n = 0;
  string phase = "R2";
  bit done = 1'b0;

  sb_item_t sb[$];
  logic hist_a[$];
  logic hist_b[$];
  logic hist_c[$];

  always #2 clk = ~clk;

  por_reset_sync dut (
    .clk_i(clk), .ext_rst_i(ext), .rst_o(rst_a)
  );

  por_reset_sync #(.DEPTH(D_B), .USE_EXT(1'b1)) u_deep (
    .clk_i(clk), .ext_rst_i(ext), .rst_o(rst_b)
  );

  por_reset_sync #(.DEPTH(D_C), .USE_EXT(1'b0)) u_pure (
    .clk_i(clk), .ext_rst_i(ext), .rst_o(rst_c)
  );

  task automatic check(input string tag, input logic act, input logic exp, input string who);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at edge %0d", tag, who, act, exp, edge_n);
    end
  endtask

  function automatic string pick_tag(input int depth, input string ph);
    return (edge_n < depth) ? "R1" : ph;
  endfunction

  // Reference model: each output is a delay line preloaded with ones.
  initial begin
    for (int i = 0; i < D_A - 1; i++) hist_a.push_back(1'b1);
    for (int i = 0; i < D_B - 1; i++) hist_b.push_back(1'b1);
    for (int i = 0; i < D_C - 1; i++) hist_c.push_back(1'b1);
  end

  always @(posedge clk) begin
    sb_item_t it;
    edge_n++;
    hist_a.push_back(ext);
    hist_b.push_back(ext);
    hist_c.push_back(1'b0);
    it.inst = 0; it.exp = hist_a.pop_front(); it.tag = pick_tag(D_A, phase); sb.push_back(it);
    it.inst = 1; it.exp = hist_b.pop_front(); it.tag = pick_tag(D_B, phase); sb.push_back(it);
    it.inst = 2; it.exp = hist_c.pop_front(); it.tag = pick_tag(D_C, "R6");  sb.push_back(it);
  end

  // Monitor: compares queued expectations away from the active edge.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      sb_item_t it;
      it = sb.pop_front();
      case (it.inst)
        0: check(it.tag, rst_a, it.exp, "dut");
        1: check(it.tag, rst_b, it.exp, "u_deep");
        default: check(it.tag, rst_c, it.exp, "u_pure");
      endcase
    end
  end

  task automatic hold(input logic val, input int n, input string tag);
    @(negedge clk);
    ext = val;
    phase = tag;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // R1: power-up level before the first edge.
  initial begin
    #1;
    check("R1", rst_a, 1'b1, "dut");
    check("R1", rst_b, 1'b1, "u_deep");
    check("R1", rst_c, 1'b1, "u_pure");
  end

  initial begin
    hold(1'b0, 10, "R2");
    hold(1'b1, 1,  "R4");
    hold(1'b0, 8,  "R4");
    hold(1'b1, 3,  "R4");
    hold(1'b0, 10, "R4");
    hold(1'b1, 12, "R5");
    hold(1'b0, 3,  "R3");
    hold(1'b1, 2,  "R3");
    hold(1'b0, 1,  "R3");
    hold(1'b1, 1,  "R3");
    hold(1'b0, 12, "R2");
    repeat (2) @(negedge clk);
    @(posedge clk);
    #1;
    done = 1'b1;
    finish_run();
  end

  initial begin
    #40000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

endmodule